// File: doc/BRIEF.md
# Host-Settable Running Timestamp

This block holds a 64-bit nanosecond timestamp that a host sets and then reads back as a running time value. The block keeps its own local nanosecond time base, which advances by a fixed parameterised step on every clock cycle. For a 100 MHz clock the step is 10.

A host set is a single-cycle strobe that carries a 64-bit value. From the cycle after the strobe, the read port shows that value. The read value then grows by the step on every cycle, as the time elapsed since the set is added to it. Until the first set after reset, the read port shows zero.

All sums wrap modulo 2^64. Only reset returns the block to the unset state.

Top module: `host_timestamp`

## Requirements
- R1: While reset is asserted, and from reset release until the first set strobe, `ts_o` reads 0 no matter how many cycles pass.
- R2: After a rising clock edge at which `set_i` is 1, `ts_o` equals the `set_val_i` sampled at that edge, so the elapsed delta restarts at zero.
- R3: Once set, with `set_i` low, `ts_o` grows by exactly `NS_STEP` on each rising clock edge.
- R4: A set strobe issued after an earlier set replaces the old time at once. The old value has no further effect on `ts_o`.
- R5: Every sum wraps modulo 2^64. A time set to 2^64-5 reads 5 one cycle after the first cycle in which it is read back.
- R6: Set strobes on consecutive cycles leave `ts_o` equal to the value of the last strobe. Each intermediate value is visible for one cycle.
- R7: The set state persists across cycles and is cleared only by reset. After a reset, `ts_o` reads 0 again until a new set.
- R8: Setting the value 0 counts as a set. `ts_o` then reads 0, then NS_STEP, then 2*NS_STEP on the following cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the local time base advances on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_i | input | 1 | Host set strobe, one cycle per set |
| set_val_i | input | 64 | Time value in nanoseconds, taken when `set_i` is high |
| ts_o | output | 64 | Current timestamp: zero before a set, otherwise set value plus elapsed time |

## Verification
The running behaviour is tried with four kinds of set value:
- A large arbitrary value exposes a wrong reference capture as an off-by-one-step error.
- A value just below 2^64 shows that the sum wraps rather than saturates.
- A zero value shows that the set flag, not a non-zero value, enables the output.
- Strobes on consecutive cycles show that the last strobe wins.

A second set long after the first shows that the old offset is discarded. A reset in the middle of a run shows that the set state returns to zero.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
    localparam int unsigned TSR_WIDTH_DEF = 64;
    localparam int unsigned TSR_STEP_DEF  = 10;
endpackage

// File: rtl/tsr_timebase.sv
module tsr_timebase #(
    parameter int unsigned TS_W    = tsr_pkg::TSR_WIDTH_DEF,
    parameter int unsigned NS_STEP = tsr_pkg::TSR_STEP_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] now_o,
    output logic [TS_W-1:0] next_o
);
    localparam logic [TS_W-1:0] STEP_V = TS_W'(NS_STEP);

    typedef struct packed {
        logic [TS_W-1:0] ns;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ns = st_q.ns + STEP_V;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign now_o  = st_q.ns;
    assign next_o = st_d.ns;

    // local time advances by the step each cycle, modulo 2^TS_W
    assert_tick_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> now_o == $past(now_o) + STEP_V);
endmodule

// File: rtl/tsr_offset_reg.sv
module tsr_offset_reg #(
    parameter int unsigned TS_W = tsr_pkg::TSR_WIDTH_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_i,
    input  logic [TS_W-1:0] set_val_i,
    input  logic [TS_W-1:0] local_next_i,
    output logic            valid_o,
    output logic [TS_W-1:0] offset_o
);
    typedef struct packed {
        logic            valid;
        logic [TS_W-1:0] offset;
    } off_state_t;

    off_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i) begin
            st_d.valid  = 1'b1;
            st_d.offset = set_val_i - local_next_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o  = st_q.valid;
    assign offset_o = st_q.offset;

    assert_rise_needs_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(set_i));

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> valid_o);

    assert_offset_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !set_i |=> $stable(offset_o));
endmodule

// File: rtl/tsr_read_sum.sv
module tsr_read_sum #(
    parameter int unsigned TS_W = tsr_pkg::TSR_WIDTH_DEF
) (
    input  logic            valid_i,
    input  logic [TS_W-1:0] now_i,
    input  logic [TS_W-1:0] offset_i,
    output logic [TS_W-1:0] ts_o
);
    always_comb begin
        ts_o = '0;
        if (valid_i) ts_o = now_i + offset_i;
    end
endmodule

// File: rtl/host_timestamp.sv
module host_timestamp #(
    parameter int unsigned TS_W    = tsr_pkg::TSR_WIDTH_DEF,
    parameter int unsigned NS_STEP = tsr_pkg::TSR_STEP_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_i,
    input  logic [TS_W-1:0] set_val_i,
    output logic [TS_W-1:0] ts_o
);
    localparam logic [TS_W-1:0] STEP_V = TS_W'(NS_STEP);

    logic [TS_W-1:0] now_w, next_w, offset_w;
    logic            valid_w;

    tsr_timebase #(.TS_W(TS_W), .NS_STEP(NS_STEP)) u_timebase (
        .clk    (clk),
        .rst_n  (rst_n),
        .now_o  (now_w),
        .next_o (next_w)
    );

    tsr_offset_reg #(.TS_W(TS_W)) u_offset (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_i        (set_i),
        .set_val_i    (set_val_i),
        .local_next_i (next_w),
        .valid_o      (valid_w),
        .offset_o     (offset_w)
    );

    tsr_read_sum #(.TS_W(TS_W)) u_sum (
        .valid_i  (valid_w),
        .now_i    (now_w),
        .offset_i (offset_w),
        .ts_o     (ts_o)
    );

    assert_set_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> ts_o == $past(set_val_i));

    assert_running_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_w && !set_i) |=> ts_o == $past(ts_o) + STEP_V);
endmodule

// File: tb/tb_host_timestamp.sv
module tb_host_timestamp;
    localparam int CLK_PERIOD = 10;
    localparam int unsigned STEP = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        set_i = 1'b0;
    logic [63:0] set_val_i = '0;
    logic [63:0] ts_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    host_timestamp #(.TS_W(64), .NS_STEP(STEP)) dut (
        .clk(clk), .rst_n(rst_n), .set_i(set_i),
        .set_val_i(set_val_i), .ts_o(ts_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // drive one set strobe; returns at the negedge where the value is visible
    task automatic set_time(input logic [63:0] v);
        @(negedge clk);
        set_i = 1'b1; set_val_i = v;
        @(negedge clk);
        set_i = 1'b0; set_val_i = '0;
    endtask

    task automatic t_reset_state;
        check("R1 in reset", ts_o, 64'd0);
        @(negedge clk); rst_n = 1'b1;
        repeat (7) @(negedge clk);
        check("R1 unset after cycles", ts_o, 64'd0);
    endtask

    task automatic t_first_set;
        logic [63:0] v = 64'h0123_4567_89AB_CDEF;
        set_time(v);
        check("R2 first read", ts_o, v);
        @(negedge clk);
        check("R3 one step", ts_o, v + 64'(STEP));
        repeat (5) @(negedge clk);
        check("R3 six steps", ts_o, v + 64'(6*STEP));
    endtask

    task automatic t_override;
        logic [63:0] v = 64'h0000_0000_0010_0000;
        repeat (20) @(negedge clk);
        set_time(v);
        check("R4 override", ts_o, v);
        repeat (3) @(negedge clk);
        check("R4 runs from new value", ts_o, v + 64'(3*STEP));
    endtask

    task automatic t_back_to_back;
        @(negedge clk);
        set_i = 1'b1; set_val_i = 64'd1000;
        @(negedge clk);
        check("R6 first of pair", ts_o, 64'd1000);
        set_val_i = 64'd5000;
        @(negedge clk);
        set_i = 1'b0; set_val_i = '0;
        check("R6 last wins", ts_o, 64'd5000);
        @(negedge clk);
        check("R6 runs after pair", ts_o, 64'd5000 + 64'(STEP));
    endtask

    task automatic t_wrap;
        logic [63:0] v = 64'hFFFF_FFFF_FFFF_FFFB;
        set_time(v);
        check("R5 near top", ts_o, v);
        @(negedge clk);
        check("R5 wrapped", ts_o, 64'd5);
    endtask

    task automatic t_reset_clears;
        @(negedge clk); rst_n = 1'b0;
        #1;
        check("R7 reset clears", ts_o, 64'd0);
        @(negedge clk); rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R7 stays unset", ts_o, 64'd0);
    endtask

    task automatic t_zero_value;
        set_time(64'd0);
        check("R8 zero set", ts_o, 64'd0);
        @(negedge clk);
        check("R8 zero plus step", ts_o, 64'(STEP));
        @(negedge clk);
        check("R8 zero plus two steps", ts_o, 64'(2*STEP));
    endtask

    initial begin
        t_reset_state();
        t_first_set();
        t_override();
        t_back_to_back();
        t_wrap();
        t_reset_clears();
        t_zero_value();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule